// File: doc/BRIEF.md
# Hypercube Next-Hop Route Walker

This block routes a packet across a binary hypercube of `N_DIMS` dimensions. Each node has an `N_DIMS`-bit address, and two nodes share a link exactly when their addresses differ in one bit. When a start strobe is accepted, the block XORs the source and destination addresses to get the relative address. The number of set bits in that value is the hop distance.

The block then walks the path, one hop per clock. Each hop clears the most significant bit still set in the relative address, so the dimensions are always corrected in a fixed order. For every hop it emits the address of the neighbour reached and the index of the link used. Dimension index 0 is the address MSB (bit `N_DIMS-1`), and index d is bit `N_DIMS-1-d`. A one-cycle done pulse marks the cycle in which the destination address appears.

The controller has two states. In `ST_IDLE` it accepts a start. In `ST_WALK` further hops remain after the one now shown. `ST_IDLE` moves to `ST_WALK` when a start is accepted with a distance above one. `ST_IDLE` stays in `ST_IDLE` on no start, on a distance of zero, or on a distance of one. `ST_WALK` returns to `ST_IDLE` when the hop being issued is the last one, and otherwise stays in `ST_WALK`.

Top module: `hc_route_walker`

## Requirements
- R1: While reset is asserted and after it is released, before any start, `hop_valid`, `done` and `busy` are 0 and `distance` is 0.
- R2: In the cycle after an accepted start, `distance` equals the number of set bits in `src_addr XOR dst_addr`. It holds that value until the next accepted start.
- R3: If the source equals the destination, `done` is 1 for exactly the one cycle after the start, `hop_valid` stays 0 and `distance` is 0.
- R4: Every emitted `hop_addr` differs in exactly one bit from the previous node of the path. For the first hop, the previous node is the source.
- R5: Each hop flips the most significant bit in which the current node still differs from the destination. `hop_dim` reports that bit as index d = `N_DIMS-1-bit`.
- R6: Along one path, `hop_dim` is strictly increasing from hop to hop.
- R7: Hops are emitted on consecutive cycles. The first hop appears in the cycle after the accepted start, and the number of cycles with `hop_valid` equals the distance.
- R8: `done` is high for one cycle only. For a nonzero distance it coincides with the hop whose `hop_addr` equals the destination.
- R9: A start raised while `busy` is 1 is ignored, and the path in progress continues unchanged. A start in the cycle where `busy` is 0, including the `done` cycle, is accepted.
- R10: `busy` (state `ST_WALK`) is 1 in every hop cycle except the last hop of a path, and 0 otherwise.
- R11: With 8 dimensions, a route from 0x86 to 0xD7 gives distance 3 and the hops 0xC6 (dim 1), 0xD6 (dim 3) and 0xD7 (dim 7), with `done` on the last hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to route; accepted only while `busy` is 0 |
| src_addr | input | N_DIMS | Source node address, sampled on accept |
| dst_addr | input | N_DIMS | Destination node address, sampled on accept |
| busy | output | 1 | More hops follow the one currently shown |
| hop_valid | output | 1 | `hop_addr` and `hop_dim` carry a hop this cycle |
| hop_addr | output | N_DIMS | Address of the node reached by this hop |
| hop_dim | output | clog2(N_DIMS) | Dimension index of this hop, 0 = address MSB |
| distance | output | clog2(N_DIMS+1) | Hop count of the most recently accepted route |
| done | output | 1 | One-cycle pulse when the destination is reached |

## Verification
The assertions rely on `start`, `src_addr` and `dst_addr` being stable around the rising edge and on the design being reset before use. They place no constraint on when `start` may arrive, because a start during a walk must be harmless. The stimulus drives inputs one nanosecond after the rising edge, so the values are settled well before the next edge. It also deliberately raises `start` with fresh addresses while a walk is in progress, holds `start` high across `done` cycles, and injects equal source and destination pairs. This exercises the acceptance rule from both sides.

// File: rtl/hc_route_pkg.sv
package hc_route_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

endpackage

// File: rtl/hc_popcount.sv
module hc_popcount #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end

    always_comb begin
        assert_count_range_R2: assert (32'(cnt) <= W);
    end
endmodule

// File: rtl/hc_first_diff.sv
module hc_first_diff #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  rel,
    output logic          found,
    output logic [W-1:0]  mask,
    output logic [IW-1:0] dim
);
    logic [W:0] above_set;

    assign above_set[W] = 1'b0;

    genvar g;
    generate
        for (g = W - 1; g >= 0; g--) begin : g_scan
            assign above_set[g] = above_set[g+1] | rel[g];
            assign mask[g]      = rel[g] & ~above_set[g+1];
        end
    endgenerate

    assign found = above_set[0];

    always_comb begin
        dim = '0;
        for (int b = 0; b < W; b++) begin
            if (mask[b]) begin
                dim = dim | IW'(W - 1 - b);
            end
        end
    end

    always_comb begin
        assert_mask_onehot_R5: assert ($onehot0(mask));
    end
endmodule

// File: rtl/hc_hop_calc.sv
module hc_hop_calc #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  here,
    input  logic [W-1:0]  target,
    output logic          differs,
    output logic [W-1:0]  next_addr,
    output logic [IW-1:0] next_dim,
    output logic [CW-1:0] remaining
);
    logic [W-1:0] rel;
    logic [W-1:0] flip;

    assign rel = here ^ target;

    hc_popcount #(.W(W), .CW(CW)) u_count (
        .vec (rel),
        .cnt (remaining)
    );

    hc_first_diff #(.W(W), .IW(IW)) u_first (
        .rel   (rel),
        .found (differs),
        .mask  (flip),
        .dim   (next_dim)
    );

    assign next_addr = here ^ flip;
endmodule

// File: rtl/hc_route_walker.sv
module hc_route_walker
    import hc_route_pkg::*;
#(
    parameter int N_DIMS = 8,
    parameter int IW     = (N_DIMS > 1) ? $clog2(N_DIMS) : 1,
    parameter int CW     = $clog2(N_DIMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_DIMS-1:0] src_addr,
    input  logic [N_DIMS-1:0] dst_addr,
    output logic              busy,
    output logic              hop_valid,
    output logic [N_DIMS-1:0] hop_addr,
    output logic [IW-1:0]     hop_dim,
    output logic [CW-1:0]     distance,
    output logic              done
);
    walk_state_e       state_q, state_d;
    logic [N_DIMS-1:0] dst_q;
    logic [N_DIMS-1:0] addr_q;
    logic [IW-1:0]     dim_q;
    logic [CW-1:0]     dist_q;
    logic              valid_q;
    logic              done_q;

    logic [N_DIMS-1:0] calc_here;
    logic [N_DIMS-1:0] calc_target;
    logic              calc_differs;
    logic [N_DIMS-1:0] calc_next;
    logic [IW-1:0]     calc_dim;
    logic [CW-1:0]     calc_left;
    logic              last_hop;

    assign calc_here   = (state_q == ST_WALK) ? addr_q : src_addr;
    assign calc_target = (state_q == ST_WALK) ? dst_q  : dst_addr;
    assign last_hop    = (calc_left == CW'(1));

    hc_hop_calc #(.W(N_DIMS), .IW(IW), .CW(CW)) u_calc (
        .here      (calc_here),
        .target    (calc_target),
        .differs   (calc_differs),
        .next_addr (calc_next),
        .next_dim  (calc_dim),
        .remaining (calc_left)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && calc_differs && !last_hop) state_d = ST_WALK;
            ST_WALK: if (last_hop)                           state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and path registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_q   <= '0;
            addr_q  <= '0;
            dim_q   <= '0;
            dist_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        dst_q  <= dst_addr;
                        dist_q <= calc_left;
                        if (calc_differs) begin
                            valid_q <= 1'b1;
                            addr_q  <= calc_next;
                            dim_q   <= calc_dim;
                            done_q  <= last_hop;
                        end else begin
                            valid_q <= 1'b0;
                            done_q  <= 1'b1;
                        end
                    end else begin
                        valid_q <= 1'b0;
                        done_q  <= 1'b0;
                    end
                end
                ST_WALK: begin
                    valid_q <= 1'b1;
                    addr_q  <= calc_next;
                    dim_q   <= calc_dim;
                    done_q  <= last_hop;
                end
                default: begin
                    valid_q <= 1'b0;
                    done_q  <= 1'b0;
                end
            endcase
        end
    end

    assign busy      = (state_q == ST_WALK);
    assign hop_valid = valid_q;
    assign hop_addr  = addr_q;
    assign hop_dim   = dim_q;
    assign distance  = dist_q;
    assign done      = done_q;

    assert_dist_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (32'(distance) == $countones($past(src_addr ^ dst_addr))));

    assert_zero_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hop_valid) |-> (distance == '0));

    assert_single_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hop_valid && $past(hop_valid) && !$past(done))
            |-> ($countones(hop_addr ^ $past(hop_addr)) == 1));

    assert_dim_rising_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hop_valid && $past(hop_valid) && !$past(done)) |-> (hop_dim > $past(hop_dim)));

    assert_walk_emits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> hop_valid);

    assert_done_at_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hop_valid) |-> (hop_addr == dst_q));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    assert_busy_not_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

// File: tb/hc_route_walker_tb.sv
module hc_route_walker_tb;
    localparam int N  = 8;
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  src_addr = '0;
    logic [N-1:0]  dst_addr = '0;
    logic          busy, hop_valid, done;
    logic [N-1:0]  hop_addr;
    logic [IW-1:0] hop_dim;
    logic [CW-1:0] distance;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hc_route_walker #(.N_DIMS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .busy(busy), .hop_valid(hop_valid), .hop_addr(hop_addr),
        .hop_dim(hop_dim), .distance(distance), .done(done)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    int q_addr[$];
    int q_dim[$];
    bit e_valid, e_done, e_busy;
    int e_addr, e_dim, e_dist;
    bit m_new_path;
    int m_src;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr.delete(); q_dim.delete();
            e_valid = 0; e_done = 0; e_busy = 0;
            e_addr = 0; e_dim = 0; e_dist = 0; m_new_path = 0; m_src = 0;
        end else begin
            bit took;
            took = 0;
            m_new_path = 0;
            if (q_addr.size() == 0 && start) begin
                logic [N-1:0] a;
                a = src_addr;
                e_dist = $countones(src_addr ^ dst_addr);
                for (int d = 0; d < N; d++) begin
                    if (a[N-1-d] != dst_addr[N-1-d]) begin
                        a[N-1-d] = dst_addr[N-1-d];
                        q_addr.push_back(int'(a));
                        q_dim.push_back(d);
                    end
                end
                took = 1; m_new_path = 1; m_src = int'(src_addr);
            end
            if (q_addr.size() > 0) begin
                e_addr = q_addr.pop_front();
                e_dim  = q_dim.pop_front();
                e_valid = 1;
                e_done = (q_addr.size() == 0);
            end else begin
                e_valid = 0;
                e_done = took;
            end
            e_busy = (q_addr.size() > 0);
        end
    end

    // per-cycle comparison
    int p_addr;
    int p_dim;
    bit p_first;

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(!hop_valid && !done && !busy && distance == 0, "R1 reset outputs",
                {hop_valid, done, busy, distance}, 0);
        end else if (!finished) begin
            chk(hop_valid == e_valid, "R7 hop_valid", hop_valid, e_valid);
            chk(done == e_done, "R8 done", done, e_done);
            chk(busy == e_busy, "R10/R9 busy", busy, e_busy);
            chk(int'(distance) == e_dist, "R2 distance", distance, e_dist);
            if (e_done && !e_valid)
                chk(distance == 0, "R3 zero distance", distance, 0);
            if (e_valid) begin
                chk(int'(hop_addr) == e_addr, "R5 hop_addr", hop_addr, e_addr);
                chk(int'(hop_dim) == e_dim, "R6 hop_dim", hop_dim, e_dim);
            end
            if (m_new_path) begin
                p_addr = m_src; p_first = 1;
            end
            if (hop_valid) begin
                chk($countones(int'(hop_addr) ^ p_addr) == 1, "R4 one-bit hop",
                    int'(hop_addr) ^ p_addr, 1);
                if (!p_first)
                    chk(int'(hop_dim) > p_dim, "R6 increasing dim", hop_dim, p_dim + 1);
                p_addr = int'(hop_addr); p_dim = int'(hop_dim); p_first = 0;
            end
        end
    end

    task automatic drive(bit s, int src, int dst);
        @(posedge clk); #1;
        start = s; src_addr = N'(src); dst_addr = N'(dst);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(0, 0, 0);
        // R11 worked example
        drive(1, 'h86, 'hD7);
        drive(0, 0, 0);
        @(negedge clk);
        chk(distance == 3, "R11 distance", distance, 3);
        chk(hop_addr == 'hC6 && hop_dim == 1, "R11 hop1", hop_addr, 'hC6);
        @(negedge clk);
        chk(hop_addr == 'hD6 && hop_dim == 3, "R11 hop2", hop_addr, 'hD6);
        @(negedge clk);
        chk(hop_addr == 'hD7 && hop_dim == 7 && done, "R11 hop3", hop_addr, 'hD7);
        // R3 equal addresses
        drive(1, 'h5A, 'h5A);
        drive(0, 0, 0);
        @(negedge clk);
        chk(done && !hop_valid, "R3 immediate done", {done, hop_valid}, 2);
        // R9 full-distance walk with starts during the walk
        drive(1, 'h00, 'hFF);
        for (int i = 0; i < 6; i++) drive(1, 'h33, 'h34);
        drive(0, 0, 0);
        repeat (4) @(posedge clk);
        // R9 start held high across done cycles, single-bit routes
        for (int i = 0; i < 6; i++) drive(1, i, i ^ 1);
        drive(0, 0, 0);
        // random traffic, mixed starts, some equal pairs
        for (int i = 0; i < 800; i++) begin
            int s, d;
            s = int'($urandom_range(0, 255));
            d = ($urandom_range(0, 7) == 0) ? s : int'($urandom_range(0, 255));
            drive($urandom_range(0, 1) == 1, s, d);
        end
        drive(0, 0, 0);
        repeat (12) @(posedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule